// File: doc/BRIEF.md
# I2C Serial Clock Timebase

This block produces the bit-level timing of the serial clock for an I2C master. A programmable prescaler divides the input clock by (prescaler + 1) to form a module clock. That module clock then paces a low phase and a high phase of SCL, each programmed separately. Each phase lasts its programmed count plus an offset. The offset is 7 when the prescaler is 0, 6 when it is 1, and 5 for any larger prescaler.

A module enable bit works as a reset. While it is clear, the timebase is held off and captures the three configuration inputs. Setting the bit freezes them. A run request starts clocking. Each period begins with SCL pulled low. The period ends after the high phase, and if the request has been dropped by then, SCL stays released. Two single-cycle strobes tell a bit engine when to change data, in the middle of the low phase, and when to sample, in the middle of the high phase.

The controller has four states: `PH_OFF`, `PH_IDLE`, `PH_LOW` and `PH_HIGH`.
- Clearing the enable sends any state to `PH_OFF`.
- With the enable set, `PH_OFF` goes to `PH_IDLE`.
- `PH_IDLE` goes to `PH_LOW` when the run request is high.
- `PH_LOW` goes to `PH_HIGH` on the last module clock of the low phase.
- `PH_HIGH` goes to `PH_LOW` on its last module clock if the run request is high, and to `PH_IDLE` if it is low.

Top module: `i2c_scl_timebase`

## Requirements
- R1: While `rst_ni` is low or `mod_en_i` is low, `scl_drive_o`, `low_mid_o` and `high_mid_o` are all 0.
- R2: `presc_i`, `low_cnt_i` and `high_cnt_i` are captured only on clock edges where `mod_en_i` is low. Changes made while it is high have no effect on phase lengths until it has been cleared and set again.
- R3: One module clock lasts (P+1) input clock cycles, where P is the captured prescaler. The low phase lasts (L+d)·(P+1) input cycles, where L is the captured low count.
- R4: The offset d is 7 for P=0, 6 for P=1, and 5 for P≥2.
- R5: A period starts with the low phase. When the block is idle and `run_i` is high at a clock edge, `scl_drive_o` is 1 (pull SCL low) from that edge on.
- R6: The high phase (`scl_drive_o`=0) lasts (H+d)·(P+1) input cycles, where H is the captured high count.
- R7: `low_mid_o` is high for exactly one input cycle per low phase. That cycle is the last input cycle of module clock number floor((L+d)/2), counted from 0 within the phase, which is cycle (floor((L+d)/2)·(P+1)+P) from the start of the phase.
- R8: `high_mid_o` is high for exactly one input cycle per high phase. That cycle sits at the same position within the phase, with H in place of L. It is never high at the same time as `low_mid_o`.
- R9: If `run_i` is low at the last module clock of a high phase, the block returns to idle and SCL stays released. If `run_i` is held high, low and high phases alternate without a gap.
- R10: Clearing `mod_en_i` in the middle of a phase releases SCL from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Module enable; low holds the timebase off and captures configuration |
| run_i | input | 1 | Request to generate SCL periods |
| presc_i | input | 8 | Prescaler value P |
| low_cnt_i | input | 16 | Low phase count L |
| high_cnt_i | input | 16 | High phase count H |
| scl_drive_o | output | 1 | 1 = pull SCL low, 0 = release |
| low_mid_o | output | 1 | Strobe in the middle of the low phase (data change point) |
| high_mid_o | output | 1 | Strobe in the middle of the high phase (sample point) |

## Verification
The assertions assume that configuration inputs matter only while `mod_en_i` is low. They also assume that `mod_en_i` is held low across reset, so the captured values are always the ones that were presented. The stimulus changes `presc_i`, `low_cnt_i` and `high_cnt_i` only at falling edges. It deliberately changes them while enabled, to show they are frozen. It toggles `mod_en_i` and `run_i` only at falling edges, both in the middle of a phase and at phase ends, so every transition is taken on a clean sampled value.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_IDLE = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    localparam int unsigned OFFS_P0   = 7;
    localparam int unsigned OFFS_P1   = 6;
    localparam int unsigned OFFS_PBIG = 5;

endpackage

// File: rtl/i2c_sclgen_cfg.sv
module i2c_sclgen_cfg #(
    parameter int unsigned PSC_W = 8,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned LEN_W = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mod_en_i,
    input  logic [PSC_W-1:0] presc_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    output logic [PSC_W-1:0] presc_q,
    output logic [LEN_W-1:0] low_len_q,
    output logic [LEN_W-1:0] high_len_q,
    output logic [LEN_W-1:0] low_mid_q,
    output logic [LEN_W-1:0] high_mid_q
);
    import i2c_sclgen_pkg::*;

    logic [3:0]       offs;
    logic [LEN_W-1:0] low_len_d;
    logic [LEN_W-1:0] high_len_d;

    // phase offset picked by the raw prescaler value being captured
    always_comb begin
        if (presc_i == '0)
            offs = 4'(OFFS_P0);
        else if (presc_i == PSC_W'(1))
            offs = 4'(OFFS_P1);
        else
            offs = 4'(OFFS_PBIG);
        low_len_d  = LEN_W'(low_cnt_i)  + LEN_W'(offs);
        high_len_d = LEN_W'(high_cnt_i) + LEN_W'(offs);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            presc_q    <= '0;
            low_len_q  <= LEN_W'(OFFS_P0);
            high_len_q <= LEN_W'(OFFS_P0);
            low_mid_q  <= LEN_W'(OFFS_P0 / 2);
            high_mid_q <= LEN_W'(OFFS_P0 / 2);
        end else if (!mod_en_i) begin
            presc_q    <= presc_i;
            low_len_q  <= low_len_d;
            high_len_q <= high_len_d;
            low_mid_q  <= low_len_d >> 1;
            high_mid_q <= high_len_d >> 1;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mod_en_i && $past(mod_en_i)) |-> ($stable(presc_q) && $stable(low_len_q) && $stable(high_len_q))) // R2
        else $error("configuration changed while enabled");

    AST_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_len_q >= LEN_W'(OFFS_PBIG)) && (high_len_q >= LEN_W'(OFFS_PBIG))) // R4
        else $error("phase length below smallest offset");

endmodule

// File: rtl/i2c_sclgen_prescale.sv
module i2c_sclgen_prescale #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic [PSC_W-1:0] presc_q,
    output logic             tick_o
);
    logic [PSC_W-1:0] div_cnt;

    assign tick_o = active_i && (div_cnt == presc_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            div_cnt <= '0;
        else if (!active_i)
            div_cnt <= '0;
        else if (div_cnt == presc_q)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + PSC_W'(1);
    end

    AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_i |-> (div_cnt <= presc_q)) // R3
        else $error("prescaler count past its limit");

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && (presc_q != '0)) |=> !tick_o) // R3
        else $error("module clock ticks too close together");

endmodule

// File: rtl/i2c_sclgen_fsm.sv
module i2c_sclgen_fsm #(
    parameter int unsigned LEN_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mod_en_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] low_len_q,
    input  logic [LEN_W-1:0] high_len_q,
    input  logic [LEN_W-1:0] low_mid_q,
    input  logic [LEN_W-1:0] high_mid_q,
    output logic             active_o,
    output logic             scl_drive_o,
    output logic             low_strobe_o,
    output logic             high_strobe_o
);
    import i2c_sclgen_pkg::*;

    phase_e           st, st_n;
    logic [LEN_W-1:0] pc, pc_n;
    logic             low_last, high_last;

    assign low_last  = (pc == low_len_q  - LEN_W'(1));
    assign high_last = (pc == high_len_q - LEN_W'(1));

    // next state and phase count
    always_comb begin
        st_n = st;
        pc_n = pc;
        if (!mod_en_i) begin
            st_n = PH_OFF;
            pc_n = '0;
        end else begin
            unique case (st)
                PH_OFF: begin
                    st_n = PH_IDLE;
                    pc_n = '0;
                end
                PH_IDLE: begin
                    pc_n = '0;
                    if (run_i)
                        st_n = PH_LOW;
                end
                PH_LOW: begin
                    if (tick_i) begin
                        if (low_last) begin
                            st_n = PH_HIGH;
                            pc_n = '0;
                        end else begin
                            pc_n = pc + LEN_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick_i) begin
                        if (high_last) begin
                            st_n = run_i ? PH_LOW : PH_IDLE;
                            pc_n = '0;
                        end else begin
                            pc_n = pc + LEN_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st <= PH_OFF;
            pc <= '0;
        end else begin
            st <= st_n;
            pc <= pc_n;
        end
    end

    // outputs
    always_comb begin
        active_o      = 1'b0;
        scl_drive_o   = 1'b0;
        low_strobe_o  = 1'b0;
        high_strobe_o = 1'b0;
        unique case (st)
            PH_OFF, PH_IDLE: begin
            end
            PH_LOW: begin
                active_o     = 1'b1;
                scl_drive_o  = 1'b1;
                low_strobe_o = tick_i && (pc == low_mid_q);
            end
            PH_HIGH: begin
                active_o      = 1'b1;
                high_strobe_o = tick_i && (pc == high_mid_q);
            end
        endcase
    end

    AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mod_en_i |=> (st == PH_OFF) && !scl_drive_o && !low_strobe_o && !high_strobe_o) // R10
        else $error("outputs active after enable cleared");

    AST_RUN_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == PH_IDLE && run_i && mod_en_i) |=> scl_drive_o) // R5
        else $error("period did not start with low phase");

    AST_LOW_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == PH_LOW) |-> (pc < low_len_q)) // R3
        else $error("low phase count overran");

    AST_HIGH_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == PH_HIGH) |-> (pc < high_len_q)) // R6
        else $error("high phase count overran");

    AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == PH_HIGH && tick_i && high_last && !run_i && mod_en_i) |=> (st == PH_IDLE && !scl_drive_o)) // R9
        else $error("did not return to idle after last high tick");

    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == PH_IDLE) |-> (pc == '0) && !tick_i) // R9
        else $error("counters not at rest in idle");

endmodule

// File: rtl/i2c_scl_timebase.sv
module i2c_scl_timebase #(
    parameter int unsigned PSC_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mod_en_i,
    input  logic             run_i,
    input  logic [PSC_W-1:0] presc_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    output logic             scl_drive_o,
    output logic             low_mid_o,
    output logic             high_mid_o
);
    localparam int unsigned LEN_W = CNT_W + 1;

    logic [PSC_W-1:0] presc_q;
    logic [LEN_W-1:0] low_len_q, high_len_q, low_mid_q, high_mid_q;
    logic             tick, active;

    i2c_sclgen_cfg #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mod_en_i   (mod_en_i),
        .presc_i    (presc_i),
        .low_cnt_i  (low_cnt_i),
        .high_cnt_i (high_cnt_i),
        .presc_q    (presc_q),
        .low_len_q  (low_len_q),
        .high_len_q (high_len_q),
        .low_mid_q  (low_mid_q),
        .high_mid_q (high_mid_q)
    );

    i2c_sclgen_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .presc_q  (presc_q),
        .tick_o   (tick)
    );

    i2c_sclgen_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mod_en_i      (mod_en_i),
        .run_i         (run_i),
        .tick_i        (tick),
        .low_len_q     (low_len_q),
        .high_len_q    (high_len_q),
        .low_mid_q     (low_mid_q),
        .high_mid_q    (high_mid_q),
        .active_o      (active),
        .scl_drive_o   (scl_drive_o),
        .low_strobe_o  (low_mid_o),
        .high_strobe_o (high_mid_o)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(low_mid_o && high_mid_o)) // R8
        else $error("both strobes at once");

    AST_LOW_STROBE_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_mid_o |-> scl_drive_o) // R7
        else $error("low strobe outside low phase");

    AST_HIGH_STROBE_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        high_mid_o |-> (!scl_drive_o && mod_en_i)) // R8
        else $error("high strobe outside high phase");

endmodule

// File: tb/i2c_scl_timebase_test.sv
module i2c_scl_timebase_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  presc = 8'd0;
    logic [15:0] low_cnt = 16'd0;
    logic [15:0] high_cnt = 16'd0;
    logic        scl_drive, low_mid, high_mid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_scl_timebase uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mod_en_i    (mod_en),
        .run_i       (run),
        .presc_i     (presc),
        .low_cnt_i   (low_cnt),
        .high_cnt_i  (high_cnt),
        .scl_drive_o (scl_drive),
        .low_mid_o   (low_mid),
        .high_mid_o  (high_mid)
    );

    function automatic int offs(input int p);
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 off, 1 idle, 2 low, 3 high
    int m_st = 0, m_cnt = 0, m_pc = 0, m_p = 0, m_l = 7, m_h = 7;
    int m_len;
    bit m_tk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pc = 0; m_p = 0; m_l = 7; m_h = 7;
        end else begin
            m_tk = (m_st >= 2) && (m_cnt == m_p);
            if (m_st >= 2) m_cnt = m_tk ? 0 : m_cnt + 1;
            else           m_cnt = 0;
            if (!mod_en) begin
                m_st = 0; m_pc = 0;
                m_p = int'(presc);
                m_l = int'(low_cnt) + offs(int'(presc));
                m_h = int'(high_cnt) + offs(int'(presc));
            end else begin
                case (m_st)
                    0: m_st = 1;
                    1: begin m_pc = 0; if (run) m_st = 2; end
                    default: if (m_tk) begin
                        m_len = (m_st == 2) ? m_l : m_h;
                        if (m_pc == m_len - 1) begin
                            m_pc = 0;
                            m_st = (m_st == 2) ? 3 : (run ? 2 : 1);
                        end else m_pc++;
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit etk;
            etk = (m_st >= 2) && (m_cnt == m_p);
            chk(scl_drive === (m_st == 2), "R5 drive vs model", int'(scl_drive), int'(m_st == 2));
            chk(low_mid === (m_st == 2 && etk && m_pc == m_l / 2), "R7 low strobe vs model",
                int'(low_mid), int'(m_st == 2 && etk && m_pc == m_l / 2));
            chk(high_mid === (m_st == 3 && etk && m_pc == m_h / 2), "R8 high strobe vs model",
                int'(high_mid), int'(m_st == 3 && etk && m_pc == m_h / 2));
        end
    end

    // measure one phase at the given drive level: length, strobe position, strobe count
    task automatic measure(input logic lvl, output int n, output int spos, output int scnt);
        while (scl_drive !== lvl) @(negedge clk);
        n = 0; spos = -1; scnt = 0;
        while (scl_drive === lvl) begin
            if ((lvl ? low_mid : high_mid) === 1'b1) begin
                scnt++;
                spos = n;
            end
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(input int p, input int l, input int h, input string tag);
        int n, sp, sc, dl, dh;
        dl = l + offs(p);
        dh = h + offs(p);
        measure(1'b1, n, sp, sc);
        chk(n == dl * (p + 1), {"R3 R4 low length ", tag}, n, dl * (p + 1));
        chk(sc == 1, {"R7 low strobe count ", tag}, sc, 1);
        chk(sp == (dl / 2) * (p + 1) + p, {"R7 low strobe position ", tag}, sp, (dl / 2) * (p + 1) + p);
        measure(1'b0, n, sp, sc);
        chk(n == dh * (p + 1), {"R6 high length ", tag}, n, dh * (p + 1));
        chk(sc == 1, {"R8 high strobe count ", tag}, sc, 1);
        chk(sp == (dh / 2) * (p + 1) + p, {"R8 high strobe position ", tag}, sp, (dh / 2) * (p + 1) + p);
    endtask

    task automatic reconfigure(input int p, input int l, input int h);
        mod_en = 1'b0;
        presc = 8'(p); low_cnt = 16'(l); high_cnt = 16'(h);
        repeat (2) @(negedge clk);
        mod_en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(scl_drive === 1'b0 && low_mid === 1'b0 && high_mid === 1'b0, "R1 outputs in reset",
            int'({scl_drive, low_mid, high_mid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_drive === 1'b0, "R1 released while disabled", int'(scl_drive), 0);

        // P=0, d=7
        reconfigure(0, 3, 2);
        run = 1'b1;
        check_period(0, 3, 2, "p0");

        // R2: changes while enabled are ignored
        presc = 8'd2; low_cnt = 16'd20; high_cnt = 16'd30;
        check_period(0, 3, 2, "R2 frozen");

        // R10: clear enable inside the low phase
        while (scl_drive !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        mod_en = 1'b0;
        @(negedge clk);
        chk(scl_drive === 1'b0, "R10 release after enable cleared", int'(scl_drive), 0);
        repeat (10) @(negedge clk);
        chk(scl_drive === 1'b0 && low_mid === 1'b0 && high_mid === 1'b0, "R1 quiet while disabled",
            int'({scl_drive, low_mid, high_mid}), 0);

        // R2: new values after reset release, P=2, d=5
        mod_en = 1'b1;
        @(negedge clk);
        check_period(2, 20, 30, "R2 new p2");

        // P=1, d=6
        reconfigure(1, 4, 6);
        check_period(1, 4, 6, "p1");

        // R9: stop and stay idle
        run = 1'b0;
        repeat (200) @(negedge clk);
        chk(scl_drive === 1'b0, "R9 idle after stop", int'(scl_drive), 0);

        // R5: start from idle goes low at the next edge
        run = 1'b1;
        @(negedge clk);
        chk(scl_drive === 1'b1, "R5 low phase first", int'(scl_drive), 1);
        run = 1'b0;
        repeat (100) @(negedge clk);
        chk(scl_drive === 1'b0, "R9 single period then idle", int'(scl_drive), 0);

        // P=3 with zero counts, then a long low phase
        reconfigure(3, 0, 0);
        run = 1'b1;
        check_period(3, 0, 0, "p3 zero");
        check_period(3, 0, 0, "R9 back to back");
        reconfigure(0, 1000, 1);
        check_period(0, 1000, 1, "long");

        run = 1'b0;
        repeat (60) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule